// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block collects the fault indications of a four-bridge motor driver and decides when the output stages must be switched off. It takes a current-limit flag from each bridge, an over-temperature flag and a supply-undervoltage flag. It drives one global disable for all bridges, a reset for the command and stepping logic, and three status bits. The fault inputs come from analog circuits that are not tied to the system clock, so each flag first passes through a two-stage synchronizer.

The three fault types follow different recovery rules:

- **Overcurrent.** A current-limit flag counts as a fault only when it persists. A run of synchronized samples in which at least one bridge flag is high must reach a parameterised length before the fault latches. A single cycle with all flags low restarts the count.
- **Over-temperature.** This fault latches at once.
- **Latch release.** Neither the overcurrent latch nor the over-temperature latch releases until the power-on reset is applied again. This stands in for removing and restoring the motor supply.
- **Undervoltage.** This fault does not latch. It holds the drivers off and the control logic in reset for as long as it lasts, and operation resumes on its own afterwards.

There is no data stream through the block. Every pin is a plain level signal, so no valid/ready handshake or back-pressure applies.

Top module: `drv_fault_supervisor`

## Requirements
- R1: Each fault input reaches the block's logic through two flip-flops. A change on `uv_flag_i` sampled at rising edge k appears on `status_uv_active_o` after edge k+1.
- R2: `status_oc_latched_o` sets once the synchronized current-limit flags have had at least one bit high on `OC_FILTER_CYCLES` consecutive rising edges. A run one sample shorter does not set it.
- R3: A single synchronized sample with all current-limit flags low restarts the overcurrent count. Two runs of `OC_FILTER_CYCLES-1` high samples separated by one low sample do not set the latch.
- R4: Once set, `status_oc_latched_o` stays at 1 after every flag returns low, until `por_n` is driven low.
- R5: `status_ot_latched_o` sets on the first synchronized high sample of `ot_flag_i` and stays at 1 until `por_n` is driven low, even after the flag clears.
- R6: `status_uv_active_o` equals the synchronized undervoltage flag, with no latching.
- R7: `ctrl_reset_o` is 1 while `por_n` is low. After that it is the synchronized undervoltage flag delayed by one clock, so the control logic is held in reset one cycle beyond the end of an undervoltage event.
- R8: `drv_disable_o` is 1 whenever any latched fault, an active undervoltage or `ctrl_reset_o` is 1. Otherwise it is 0.
- R9: Driving `por_n` low clears both latches, the overcurrent count and both synchronizers. The outputs are then: disable 1, control reset 1, all status bits 0.
- R10: The overcurrent condition is the OR of all bridge flags. A flag on any single bridge can trigger the latch, and flags that alternate between bridges with no all-low cycle count as one unbroken run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| oc_flag_i | input | NUM_BRIDGES | Per-bridge analog current-limit flags, asynchronous |
| ot_flag_i | input | 1 | Over-temperature flag, asynchronous |
| uv_flag_i | input | 1 | Supply undervoltage flag, asynchronous |
| drv_disable_o | output | 1 | Global disable for all bridges |
| ctrl_reset_o | output | 1 | Reset for command and stepping logic |
| status_oc_latched_o | output | 1 | Overcurrent fault latched |
| status_ot_latched_o | output | 1 | Over-temperature fault latched |
| status_uv_active_o | output | 1 | Undervoltage currently active |

## Verification
The assertions check four things on every cycle:
- both latches are sticky;
- the overcurrent latch rises only at the end of a full-length run;
- an all-low sample clears the count;
- an active fault always asserts the disable and is followed by the control reset.

The length of the filter window can only be shown by the bench's scenarios. These are:
- a run one sample short;
- two short runs split by a single gap;
- an alternating-bridge run;
- a single-bridge run.

The same holds for the recovery sequence after undervoltage, and for the clearing of latches by a new power-on reset. The bench compares every output against a behavioural model on every clock.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;
  typedef struct packed {
    logic oc_latched;
    logic ot_latched;
    logic uv_active;
  } fsup_status_t;
endpackage

// File: rtl/fsup_sync.sv
`timescale 1ns/1ps
module fsup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fsup_oc_filter.sv
`timescale 1ns/1ps
module fsup_oc_filter #(
  parameter int NUM_BRIDGES   = 4,
  parameter int FILTER_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] limit_s_i,
  output logic                   oc_latched_o
);
  localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_CYCLES - 1);

  logic             any_limit;
  logic [CNT_W-1:0] run_q;
  logic             latched_q;

  assign any_limit = |limit_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      latched_q <= 1'b0;
    end else begin
      if (!any_limit)       run_q <= '0;
      else if (run_q != LAST) run_q <= run_q + 1'b1;
      if (any_limit && run_q == LAST) latched_q <= 1'b1;
    end
  end

  assign oc_latched_o = latched_q;

  assert_oc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q |=> latched_q);
  assert_oc_full_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_q) |-> ($past(run_q) == LAST && $past(any_limit)));
  assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_limit |=> run_q == '0);
endmodule

// File: rtl/fsup_sticky.sv
`timescale 1ns/1ps
module fsup_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  assert_ot_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  assert_ot_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/drv_fault_supervisor.sv
`timescale 1ns/1ps
module drv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NUM_BRIDGES      = 4,
  parameter int OC_FILTER_CYCLES = 16,
  parameter int SYNC_STAGES      = 2
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic [NUM_BRIDGES-1:0] oc_flag_i,
  input  logic                   ot_flag_i,
  input  logic                   uv_flag_i,
  output logic                   drv_disable_o,
  output logic                   ctrl_reset_o,
  output logic                   status_oc_latched_o,
  output logic                   status_ot_latched_o,
  output logic                   status_uv_active_o
);
  localparam int SYNC_W = NUM_BRIDGES + 2;

  logic [SYNC_W-1:0]      raw_flags;
  logic [SYNC_W-1:0]      sync_flags;
  logic [NUM_BRIDGES-1:0] limit_s;
  logic                   ot_s;
  logic                   uv_s;
  logic                   ctrl_rst_q;
  fsup_status_t           stat;

  assign raw_flags = {uv_flag_i, ot_flag_i, oc_flag_i};

  fsup_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (por_n),
    .async_i (raw_flags),
    .sync_o  (sync_flags)
  );

  assign limit_s = sync_flags[NUM_BRIDGES-1:0];
  assign ot_s    = sync_flags[NUM_BRIDGES];
  assign uv_s    = sync_flags[NUM_BRIDGES+1];

  fsup_oc_filter #(.NUM_BRIDGES(NUM_BRIDGES), .FILTER_CYCLES(OC_FILTER_CYCLES)) u_oc (
    .clk          (clk),
    .rst_n        (por_n),
    .limit_s_i    (limit_s),
    .oc_latched_o (stat.oc_latched)
  );

  fsup_sticky u_ot (
    .clk    (clk),
    .rst_n  (por_n),
    .set_i  (ot_s),
    .flag_o (stat.ot_latched)
  );

  assign stat.uv_active = uv_s;

  // Control reset is held through power-on reset and trails undervoltage by one clock.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctrl_rst_q <= 1'b1;
    else        ctrl_rst_q <= uv_s;
  end

  assign ctrl_reset_o        = ctrl_rst_q;
  assign drv_disable_o       = stat.oc_latched | stat.ot_latched | stat.uv_active | ctrl_rst_q;
  assign status_oc_latched_o = stat.oc_latched;
  assign status_ot_latched_o = stat.ot_latched;
  assign status_uv_active_o  = stat.uv_active;

  assert_uv_sync_delay_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(status_uv_active_o) |-> $past(uv_flag_i, 2));
  assert_uv_resets_ctrl_R7: assert property (@(posedge clk) disable iff (!por_n)
    status_uv_active_o |=> ctrl_reset_o);
  assert_fault_disables_R8: assert property (@(posedge clk) disable iff (!por_n)
    (status_oc_latched_o || status_ot_latched_o || status_uv_active_o || ctrl_reset_o)
      |-> drv_disable_o);
  assert_ctrl_release_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ctrl_reset_o) |-> $past(!status_uv_active_o));
endmodule

// File: tb/drv_fault_supervisor_bench.sv
`timescale 1ns/1ps
module drv_fault_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int LIMIT      = 8;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [NB-1:0] oc_flag = '0;
  logic          ot_flag = 1'b0;
  logic          uv_flag = 1'b0;
  logic          drv_disable, ctrl_reset, st_oc, st_ot, st_uv;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  drv_fault_supervisor #(.NUM_BRIDGES(NB), .OC_FILTER_CYCLES(LIMIT), .SYNC_STAGES(2)) u_drv_fault_supervisor (
    .clk                 (clk),
    .por_n               (por_n),
    .oc_flag_i           (oc_flag),
    .ot_flag_i           (ot_flag),
    .uv_flag_i           (uv_flag),
    .drv_disable_o       (drv_disable),
    .ctrl_reset_o        (ctrl_reset),
    .status_oc_latched_o (st_oc),
    .status_ot_latched_o (st_ot),
    .status_uv_active_o  (st_uv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: queues model the synchronizer delay.
  bit m_oc_q[$], m_ot_q[$], m_uv_q[$];
  int m_run;
  bit m_oc_lat, m_ot_lat, m_ctrl;

  function automatic void model_reset();
    m_oc_q = {0, 0}; m_ot_q = {0, 0}; m_uv_q = {0, 0};
    m_run = 0; m_oc_lat = 0; m_ot_lat = 0; m_ctrl = 1;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!por_n) begin
      model_reset();
    end else begin
      bit oc_s, ot_s, uv_s;
      oc_s = m_oc_q[0]; ot_s = m_ot_q[0]; uv_s = m_uv_q[0];
      if (oc_s) m_run = m_run + 1; else m_run = 0;
      if (m_run >= LIMIT) m_oc_lat = 1;
      if (ot_s) m_ot_lat = 1;
      m_ctrl = uv_s;
      void'(m_oc_q.pop_front()); m_oc_q.push_back(|oc_flag);
      void'(m_ot_q.pop_front()); m_ot_q.push_back(ot_flag);
      void'(m_uv_q.pop_front()); m_uv_q.push_back(uv_flag);
    end
  end

  task automatic cmp(input logic act, input bit exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp(st_oc,      m_oc_lat, "R2 oc latch vs model");
    cmp(st_ot,      m_ot_lat, "R5 ot latch vs model");
    cmp(st_uv,      m_uv_q[0], "R6 uv active vs model");
    cmp(ctrl_reset, m_ctrl,   "R7 ctrl reset vs model");
    cmp(drv_disable, m_oc_lat | m_ot_lat | m_uv_q[0] | m_ctrl, "R8 disable vs model");
  end

  task automatic wait_drive(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic power_cycle();
    por_n = 1'b0; oc_flag = '0; ot_flag = 1'b0; uv_flag = 1'b0;
    wait_drive(3);
    por_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    wait_drive(3);
    cmp(drv_disable, 1, "R9 disable in reset");
    cmp(ctrl_reset,  1, "R9 ctrl reset in reset");
    cmp(st_oc | st_ot | st_uv, 0, "R9 status clear in reset");
    por_n = 1'b1;
    wait_drive(2);
    cmp(ctrl_reset, 0, "R7 ctrl reset released");
    cmp(drv_disable, 0, "R8 drivers enabled");

    // R2: run one sample short
    oc_flag = 4'b0010; wait_drive(LIMIT-1); oc_flag = '0; wait_drive(5);
    cmp(st_oc, 0, "R2 short run no latch");

    // R3: two short runs split by one low sample
    oc_flag = 4'b0001; wait_drive(LIMIT-1); oc_flag = '0; wait_drive(1);
    oc_flag = 4'b1000; wait_drive(LIMIT-1); oc_flag = '0; wait_drive(5);
    cmp(st_oc, 0, "R3 gap restarts count");

    // R10: alternating bridges form one run
    for (int i = 0; i < LIMIT; i++) begin
      oc_flag = (i % 2) ? 4'b0100 : 4'b0001;
      wait_drive(1);
    end
    oc_flag = '0; wait_drive(4);
    cmp(st_oc, 1, "R10 alternating bridges latch");
    cmp(drv_disable, 1, "R8 disable on oc");
    wait_drive(10);
    cmp(st_oc, 1, "R4 oc latch held");

    // R9: power cycle clears
    power_cycle(); wait_drive(2);
    cmp(st_oc, 0, "R9 oc cleared by por");
    cmp(drv_disable, 0, "R9 disable cleared by por");

    // R2: single bridge full run
    oc_flag = 4'b1000; wait_drive(LIMIT); oc_flag = '0; wait_drive(4);
    cmp(st_oc, 1, "R2 single bridge latch");
    power_cycle(); wait_drive(2);

    // R5: one-cycle over-temperature pulse latches
    ot_flag = 1'b1; wait_drive(1); ot_flag = 1'b0; wait_drive(4);
    cmp(st_ot, 1, "R5 ot latched");
    wait_drive(8);
    cmp(st_ot, 1, "R5 ot held after clear");
    cmp(drv_disable, 1, "R8 disable on ot");
    power_cycle(); wait_drive(2);
    cmp(st_ot, 0, "R9 ot cleared by por");

    // R1, R6, R7: undervoltage timing and recovery
    uv_flag = 1'b1;
    wait_drive(1);
    cmp(st_uv, 0, "R1 uv not yet through sync");
    wait_drive(1);
    cmp(st_uv, 1, "R1 uv after two edges");
    cmp(drv_disable, 1, "R8 disable on uv");
    wait_drive(1);
    cmp(ctrl_reset, 1, "R7 ctrl reset on uv");
    wait_drive(4);
    uv_flag = 1'b0;
    wait_drive(2);
    cmp(st_uv, 0, "R6 uv cleared");
    cmp(ctrl_reset, 1, "R7 ctrl reset held one cycle");
    wait_drive(1);
    cmp(ctrl_reset, 0, "R7 ctrl reset released");
    cmp(drv_disable, 0, "R6 auto recovery");

    wait_drive(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule